// File: doc/BRIEF.md
# Hub Configuration Loader

This block runs once after reset in a USB hub. It opens a read transaction on an external serial EEPROM over SPI and reads a format byte. That byte decides how many configuration bytes follow. The bytes fill a set of configuration registers: vendor, product and device IDs, per-port active and removable masks, an overcurrent debounce time in milliseconds, an overcurrent polarity flag, an indicator manual-mode flag and a write-protect flag. Any field the selected format does not cover keeps its built-in default.

A format byte the block does not recognise ends the transaction at once. In that case every field stays at its default and an error flag is raised. In both cases `load_done` is raised when chip select is released. The upstream pull-up enable is then driven by a synchronized VBUS-detect input. It rises only while loading is finished and VBUS is present, and it falls again when VBUS goes away.

The address width of the EEPROM is picked by a strap input. The SPI clock runs at the system clock divided by `2*CLK_DIV`.

Top module: `hub_cfg_loader`

## Requirements
- R1: While `rst_n` is low, `spi_cs_n` is 1, `spi_sclk` is 0, and `load_done`, `load_err` and `pullup_en` are 0. All configuration outputs hold their defaults: VID 0xC0DE, PID 0x2002, DID 0x0100, both port masks all ones, debounce 8, all flags 0.
- R2: The transaction starts with opcode 0x03, followed by the start address `CFG_BASE` (default 0). The address takes two bytes, high byte first, when `addr16` is 1, and only the low byte when `addr16` is 0. Every byte goes out MSB first.
- R3: SPI mode 0 is used. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sclk` is low. `spi_miso` is sampled on the rising SCLK edge.
- R4: The byte at offset 0 is the format code. With code 0xD0, offsets 1 to 6 are read as VID, PID and DID, each with its low byte first.
- R5: Code 0xD2 reads everything 0xD0 reads. In addition, offset 7 gives the active-port mask and offset 8 the removable-port mask, each taken from bits [NPORTS-1:0].
- R6: Code 0xD4 reads everything 0xD2 reads. In addition, offset 9 bits [3:0] give the debounce time in ms. Offset 10 bit 0 is overcurrent active-high, bit 1 is manual indicator mode and bit 2 is write-protect.
- R7: Fields the selected format does not reach keep the defaults listed in R1. In particular, debounce stays 8 ms unless code 0xD4 is read.
- R8: A valid load produces exactly 8*(1+A+N) SCLK rising edges, where A is the number of address bytes and N is 7, 9 or 11 for 0xD0, 0xD2 or 0xD4. `spi_cs_n` rises in the same cycle that `load_done` rises. After that, `load_done` stays 1 and the configuration outputs do not change.
- R9: Any other format code stops the read after the format byte, giving 8*(2+A) SCLK edges. All fields keep their defaults, and `load_err` and `load_done` are both 1.
- R10: `pullup_en` is 1 only when `load_done` is 1 and the synchronized VBUS is high. It rises three cycles after `vbus_det` rises, or one cycle after `load_done` if VBUS is already present. It falls three cycles after `vbus_det` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; loading starts after release |
| addr16 | input | 1 | Strap: 1 selects two-byte EEPROM addressing, 0 selects one byte |
| vbus_det | input | 1 | Upstream VBUS present (asynchronous) |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data toward the EEPROM |
| spi_miso | input | 1 | SPI data from the EEPROM |
| cfg_vid | output | 16 | Vendor ID |
| cfg_pid | output | 16 | Product ID |
| cfg_did | output | 16 | Device release ID |
| cfg_port_active | output | NPORTS | Active downstream ports |
| cfg_port_removable | output | NPORTS | Removable downstream ports |
| cfg_debounce_ms | output | 4 | Overcurrent debounce time in ms |
| cfg_ovr_active_high | output | 1 | Overcurrent input is active high |
| cfg_led_manual | output | 1 | Port indicators under host control |
| cfg_write_protect | output | 1 | Configuration write-protect |
| load_done | output | 1 | Loading finished (sticky) |
| load_err | output | 1 | Format code was not recognised |
| pullup_en | output | 1 | Upstream pull-up enable |

## Verification
`load_done`, `load_err`, the configuration outputs and the release of `spi_cs_n` all change at the same clock edge. The bench therefore polls on falling clock edges until it sees `load_done`, and reads all of them at that point. Header bytes and SCLK edge counts are captured by an EEPROM model, then compared once chip select is high. `pullup_en` trails a VBUS change by three clock edges and `load_done` by one. After each stimulus on a falling edge, the bench samples `pullup_en` on the falling edge after the second rising edge, expecting the old value, and on the falling edge after the third, expecting the new one. This pins the delay exactly.

// File: rtl/hub_cfg_pkg.sv
package hub_cfg_pkg;

  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam logic [7:0] FMT_IDS   = 8'hD0;
  localparam logic [7:0] FMT_PORTS = 8'hD2;
  localparam logic [7:0] FMT_FULL  = 8'hD4;

  typedef struct packed {
    logic [15:0] vid;
    logic [15:0] pid;
    logic [15:0] did;
    logic [7:0]  act_mask;
    logic [7:0]  rem_mask;
    logic [3:0]  debounce;
    logic        ovr_high;
    logic        led_manual;
    logic        wprot;
  } hub_cfg_t;

  typedef enum logic [2:0] {
    LD_BOOT, LD_CMD, LD_ADDR_HI, LD_ADDR_LO, LD_READ, LD_END
  } ld_state_t;

  // Total bytes read (format byte included) for a format code; 0 = unknown.
  function automatic logic [3:0] tier_bytes(input logic [7:0] fmt);
    case (fmt)
      FMT_IDS:   tier_bytes = 4'd7;
      FMT_PORTS: tier_bytes = 4'd9;
      FMT_FULL:  tier_bytes = 4'd11;
      default:   tier_bytes = 4'd0;
    endcase
  endfunction

  // Merge one data byte at offset idx into the configuration set.
  function automatic hub_cfg_t apply_byte(input hub_cfg_t c, input logic [3:0] idx,
                                          input logic [7:0] b);
    hub_cfg_t n;
    n = c;
    case (idx)
      4'd1:  n.vid[7:0]  = b;
      4'd2:  n.vid[15:8] = b;
      4'd3:  n.pid[7:0]  = b;
      4'd4:  n.pid[15:8] = b;
      4'd5:  n.did[7:0]  = b;
      4'd6:  n.did[15:8] = b;
      4'd7:  n.act_mask  = b;
      4'd8:  n.rem_mask  = b;
      4'd9:  n.debounce  = b[3:0];
      4'd10: begin
        n.ovr_high   = b[0];
        n.led_manual = b[1];
        n.wprot      = b[2];
      end
      default: n = c;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hub_spi_byte.sv
module hub_spi_byte #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(CLK_DIV - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh_tx  <= '0;
      sh_rx  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sh_tx  <= tx_byte;
          cnt    <= '0;
          bitn   <= '0;
        end
      end else if (cnt == HALF_LAST) begin
        cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          sh_rx <= {sh_rx[6:0], miso};
        end else begin
          sclk  <= 1'b0;
          sh_tx <= {sh_tx[6:0], 1'b0};
          bitn  <= bitn + 3'd1;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign mosi    = sh_tx[7];
  assign rx_byte = sh_rx;
endmodule

// File: rtl/hub_cfg_seq.sv
module hub_cfg_seq
  import hub_cfg_pkg::*;
#(
  parameter hub_cfg_t    DEF_CFG  = '0,
  parameter logic [15:0] CFG_BASE = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr16,
  input  logic       eng_done,
  input  logic [7:0] eng_rx,
  output logic       eng_start,
  output logic [7:0] eng_tx,
  output logic       cs_n,
  output hub_cfg_t   cfg,
  output logic       done,
  output logic       err
);
  ld_state_t  st;
  logic       launched;
  logic [3:0] idx;
  logic [3:0] last_idx;
  logic       xfer_state;
  logic [3:0] fmt_len;

  assign xfer_state = (st == LD_CMD) || (st == LD_ADDR_HI) ||
                      (st == LD_ADDR_LO) || (st == LD_READ);
  assign eng_start  = xfer_state && !launched;
  assign fmt_len    = tier_bytes(eng_rx);

  always_comb begin
    case (st)
      LD_CMD:     eng_tx = RD_OPCODE;
      LD_ADDR_HI: eng_tx = CFG_BASE[15:8];
      LD_ADDR_LO: eng_tx = CFG_BASE[7:0];
      default:    eng_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= LD_BOOT;
      cs_n     <= 1'b1;
      launched <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      cfg      <= DEF_CFG;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (eng_start) launched <= 1'b1;
      case (st)
        LD_BOOT: begin
          cs_n <= 1'b0;
          st   <= LD_CMD;
        end
        LD_CMD: if (eng_done) begin
          launched <= 1'b0;
          st       <= addr16 ? LD_ADDR_HI : LD_ADDR_LO;
        end
        LD_ADDR_HI: if (eng_done) begin
          launched <= 1'b0;
          st       <= LD_ADDR_LO;
        end
        LD_ADDR_LO: if (eng_done) begin
          launched <= 1'b0;
          idx      <= '0;
          st       <= LD_READ;
        end
        LD_READ: if (eng_done) begin
          launched <= 1'b0;
          if (idx == 4'd0) begin
            if (fmt_len == 4'd0) begin
              err  <= 1'b1;
              done <= 1'b1;
              cs_n <= 1'b1;
              st   <= LD_END;
            end else begin
              last_idx <= fmt_len - 4'd1;
              idx      <= 4'd1;
            end
          end else begin
            cfg <= apply_byte(cfg, idx, eng_rx);
            if (idx == last_idx) begin
              done <= 1'b1;
              cs_n <= 1'b1;
              st   <= LD_END;
            end else begin
              idx <= idx + 4'd1;
            end
          end
        end
        default: st <= LD_END;
      endcase
    end
  end
endmodule

// File: rtl/hub_attach.sv
module hub_attach #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vbus_det,
  input  logic load_done,
  output logic vbus_ok,
  output logic pullup_en
);
  logic [SYNC_STAGES-1:0] sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= '0;
      pullup_en <= 1'b0;
    end else begin
      sync      <= {sync[SYNC_STAGES-2:0], vbus_det};
      pullup_en <= load_done && sync[SYNC_STAGES-1];
    end
  end

  assign vbus_ok = sync[SYNC_STAGES-1];
endmodule

// File: rtl/hub_cfg_loader.sv
module hub_cfg_loader
  import hub_cfg_pkg::*;
#(
  parameter int          NPORTS       = 2,
  parameter int          CLK_DIV      = 2,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [15:0] CFG_BASE     = 16'h0000,
  parameter logic [15:0] DEF_VID      = 16'hC0DE,
  parameter logic [15:0] DEF_PID      = 16'h2002,
  parameter logic [15:0] DEF_DID      = 16'h0100,
  parameter logic [3:0]  DEF_DEBOUNCE = 4'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr16,
  input  logic              vbus_det,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [15:0]       cfg_vid,
  output logic [15:0]       cfg_pid,
  output logic [15:0]       cfg_did,
  output logic [NPORTS-1:0] cfg_port_active,
  output logic [NPORTS-1:0] cfg_port_removable,
  output logic [3:0]        cfg_debounce_ms,
  output logic              cfg_ovr_active_high,
  output logic              cfg_led_manual,
  output logic              cfg_write_protect,
  output logic              load_done,
  output logic              load_err,
  output logic              pullup_en
);
  localparam logic [7:0] ALL_PORTS = 8'((16'd1 << NPORTS) - 16'd1);
  localparam hub_cfg_t DEF_CFG = '{
    vid: DEF_VID, pid: DEF_PID, did: DEF_DID,
    act_mask: ALL_PORTS, rem_mask: ALL_PORTS,
    debounce: DEF_DEBOUNCE, ovr_high: 1'b0, led_manual: 1'b0, wprot: 1'b0
  };

  logic       eng_start;
  logic [7:0] eng_tx;
  logic       eng_done;
  logic [7:0] eng_rx;
  hub_cfg_t   cfg;
  logic       vbus_ok;
  logic       unused_mask_bits;

  hub_spi_byte #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx),
    .done(eng_done), .rx_byte(eng_rx), .sclk(spi_sclk), .mosi(spi_mosi),
    .miso(spi_miso)
  );

  hub_cfg_seq #(.DEF_CFG(DEF_CFG), .CFG_BASE(CFG_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr16(addr16), .eng_done(eng_done),
    .eng_rx(eng_rx), .eng_start(eng_start), .eng_tx(eng_tx),
    .cs_n(spi_cs_n), .cfg(cfg), .done(load_done), .err(load_err)
  );

  hub_attach #(.SYNC_STAGES(SYNC_STAGES)) u_att (
    .clk(clk), .rst_n(rst_n), .vbus_det(vbus_det), .load_done(load_done),
    .vbus_ok(vbus_ok), .pullup_en(pullup_en)
  );

  assign cfg_vid             = cfg.vid;
  assign cfg_pid             = cfg.pid;
  assign cfg_did             = cfg.did;
  assign cfg_port_active     = cfg.act_mask[NPORTS-1:0];
  assign cfg_port_removable  = cfg.rem_mask[NPORTS-1:0];
  assign cfg_debounce_ms     = cfg.debounce;
  assign cfg_ovr_active_high = cfg.ovr_high;
  assign cfg_led_manual      = cfg.led_manual;
  assign cfg_write_protect   = cfg.wprot;
  assign unused_mask_bits    = ^{cfg.act_mask, cfg.rem_mask};
endmodule

// File: rtl/hub_cfg_loader_chk.sv
module hub_cfg_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        spi_mosi,
  input logic        load_done,
  input logic        load_err,
  input logic        pullup_en,
  input logic        vbus_ok,
  input logic [15:0] cfg_vid,
  input logic [3:0]  cfg_debounce_ms
);
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
  assert_cs_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> spi_cs_n);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && $past(load_done)) |-> ($stable(cfg_vid) && $stable(cfg_debounce_ms)));
  assert_err_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> load_done);
  assert_pullup_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_en |-> load_done);
  assert_pullup_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vbus_ok) |-> !pullup_en);
  assert_pullup_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vbus_ok) && $past(load_done)) |-> pullup_en);
endmodule

bind hub_cfg_loader hub_cfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .load_done(load_done), .load_err(load_err),
  .pullup_en(pullup_en), .vbus_ok(vbus_ok), .cfg_vid(cfg_vid),
  .cfg_debounce_ms(cfg_debounce_ms)
);

// File: tb/tb_hub_cfg_loader.sv
module tb_hub_cfg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr16 = 1'b0;
  logic vbus_det = 1'b0;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  logic [15:0] cfg_vid, cfg_pid, cfg_did;
  logic [1:0]  cfg_port_active, cfg_port_removable;
  logic [3:0]  cfg_debounce_ms;
  logic cfg_ovr_active_high, cfg_led_manual, cfg_write_protect;
  logic load_done, load_err, pullup_en;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  hub_cfg_loader dut (
    .clk(clk), .rst_n(rst_n), .addr16(addr16), .vbus_det(vbus_det),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .cfg_vid(cfg_vid), .cfg_pid(cfg_pid),
    .cfg_did(cfg_did), .cfg_port_active(cfg_port_active),
    .cfg_port_removable(cfg_port_removable), .cfg_debounce_ms(cfg_debounce_ms),
    .cfg_ovr_active_high(cfg_ovr_active_high), .cfg_led_manual(cfg_led_manual),
    .cfg_write_protect(cfg_write_protect), .load_done(load_done),
    .load_err(load_err), .pullup_en(pullup_en)
  );

  // EEPROM model, SPI mode 0
  logic [7:0]  mem [0:15];
  logic [31:0] hdr;
  int nrise;
  int hdr_bits;
  int d;

  always @(negedge spi_cs_n) begin
    nrise = 0;
    hdr   = 0;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (nrise < hdr_bits) hdr = {hdr[30:0], spi_mosi};
      nrise = nrise + 1;
    end
  end

  always @(negedge spi_sclk) begin
    d = nrise - hdr_bits;
    if (d >= 0 && d < 128) spi_miso = mem[d / 8][7 - (d % 8)];
    else spi_miso = 1'b0;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int tb_len(input logic [7:0] f);
    if (f == 8'hD0) return 7;
    if (f == 8'hD2) return 9;
    if (f == 8'hD4) return 11;
    return 0;
  endfunction

  task automatic run_case(input logic [7:0] fmt, input logic a16, input int seed,
                          input logic vb_early);
    int len;
    int waited;
    int abytes;
    len    = tb_len(fmt);
    abytes = a16 ? 2 : 1;
    mem[0] = fmt;
    for (int i = 1; i < 16; i++) mem[i] = 8'((i * 37 + seed * 11 + 5) & 255);
    addr16   = a16;
    hdr_bits = 8 * (1 + abytes);
    vbus_det = vb_early;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n", 32'(spi_cs_n), 1);
    chk("R1", "sclk", 32'(spi_sclk), 0);
    chk("R1", "done/err/pullup", {29'd0, load_done, load_err, pullup_en}, 0);
    chk("R1", "vid", 32'(cfg_vid), 32'h0000C0DE);
    chk("R1", "debounce", 32'(cfg_debounce_ms), 8);
    rst_n = 1'b1;
    waited = 0;
    while (!load_done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    chk("R8", "load_done reached", 32'(load_done), 1);
    chk("R8", "cs_n released", 32'(spi_cs_n), 1);
    chk("R3", "sclk idle after load", 32'(spi_sclk), 0);
    // R2 header: opcode then address bytes
    chk("R2", "header", hdr, a16 ? 32'h00030000 : 32'h00000300);
    if (len == 0) begin
      chk("R9", "sclk edges", 32'(nrise), 32'(hdr_bits + 8));
      chk("R9", "load_err", 32'(load_err), 1);
    end else begin
      chk("R8", "sclk edges", 32'(nrise), 32'(hdr_bits + 8 * len));
      chk("R8", "load_err", 32'(load_err), 0);
    end
    // R4 ids
    chk("R4", "vid", 32'(cfg_vid), (len >= 7) ? {16'd0, mem[2], mem[1]} : 32'h0000C0DE);
    chk("R4", "pid", 32'(cfg_pid), (len >= 7) ? {16'd0, mem[4], mem[3]} : 32'h00002002);
    chk("R4", "did", 32'(cfg_did), (len >= 7) ? {16'd0, mem[6], mem[5]} : 32'h00000100);
    // R5 masks, R7 defaults
    chk(len >= 9 ? "R5" : "R7", "active", 32'(cfg_port_active),
        (len >= 9) ? 32'(mem[7][1:0]) : 3);
    chk(len >= 9 ? "R5" : "R7", "removable", 32'(cfg_port_removable),
        (len >= 9) ? 32'(mem[8][1:0]) : 3);
    // R6 options, R7 default debounce
    chk(len >= 11 ? "R6" : "R7", "debounce", 32'(cfg_debounce_ms),
        (len >= 11) ? 32'(mem[9][3:0]) : 8);
    chk(len >= 11 ? "R6" : "R7", "flags",
        {29'd0, cfg_ovr_active_high, cfg_led_manual, cfg_write_protect},
        (len >= 11) ? {29'd0, mem[10][0], mem[10][1], mem[10][2]} : 0);
    // R10 attach timing
    if (vb_early) begin
      chk("R10", "pullup same cycle as done", 32'(pullup_en), 0);
      @(negedge clk);
      chk("R10", "pullup one cycle after done", 32'(pullup_en), 1);
      vbus_det = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10", "pullup held 2 cycles after vbus loss", 32'(pullup_en), 1);
      @(negedge clk);
      chk("R10", "pullup dropped 3 cycles after vbus loss", 32'(pullup_en), 0);
    end else begin
      repeat (10) @(negedge clk);
      chk("R10", "pullup off without vbus", 32'(pullup_en), 0);
      vbus_det = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10", "pullup off 2 cycles after vbus", 32'(pullup_en), 0);
      @(negedge clk);
      chk("R10", "pullup on 3 cycles after vbus", 32'(pullup_en), 1);
      @(negedge clk);
      chk("R8", "vid frozen after done",
          32'(cfg_vid), (len >= 7) ? {16'd0, mem[2], mem[1]} : 32'h0000C0DE);
    end
  endtask

  initial begin
    automatic logic [7:0] fmts [0:4] = '{8'hD0, 8'hD2, 8'hD4, 8'h5A, 8'hD1};
    hdr_bits = 16;
    for (int a = 0; a < 2; a++) begin
      for (int f = 0; f < 5; f++) begin
        run_case(fmts[f], a[0], a * 5 + f, (f % 2) == a);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule